// File: doc/BRIEF.md
# Memory Protection Range Checker

This block decides, one access at a time, whether a bus requestor may touch an address. Each access presents an address, a requestor privilege ID, a privilege level (user or supervisor) and a kind (read, write or execute). The address is compared against one range whose bounds are fixed when the block is built and against `NUM_PROG` ranges whose bounds software writes. Every range carries a 32-bit permission word. When more than one range matches, the permission words of all matching ranges are ANDed. The access is allowed only if the combined word grants both the needed level/kind bit and the requestor's ID bit. An address that matches no range follows a global default mode.

The verdict is registered and appears one clock after the request. A denied access also records its address, ID, level and kind in fault registers and sets a sticky fault flag. Software clears the flag by writing one to a clear bit. A small write-only register port programs the range bounds, the permission words, the default mode and the fault clear.

Top module: `mpu_range_checker`

## Requirements
- R1: The fixed range covers `FIXED_START` to `FIXED_END` inclusive. Its permission word is written at index `NUM_PROG`, select 2, and resets to `FIXED_PERM_RST`.
- R2: Programmable range i matches an address that is at least its start and at most its end. A range whose end is below its start matches nothing. Its start, end and permission word are written at index i (`reg_addr[REG_AW-1:2]`) with select (`reg_addr[1:0]`) 0, 1 and 2 respectively.
- R3: When several ranges match, their permission words are ANDed bit by bit. Any matching range that refuses the access therefore denies it.
- R4: An address that matches no range is allowed when the default-mode bit is 1 and denied when it is 0. The default-mode bit is bit 0 written at index `NUM_PROG`, select 0.
- R5: Permission bits are: user execute bit 0, user write bit 1, user read bit 2, supervisor execute bit 3, supervisor write bit 4, supervisor read bit 5. The level input is 0 for user and 1 for supervisor. The kind input is 0 for read, 1 for write, 2 for execute and 3 for reserved. A reserved kind is always denied when any range matches.
- R6: Bits 10+n (n = 0..11) grant privilege ID n. Bit 9 grants every ID above 11. A matching access is allowed only when both the R5 bit and the ID bit are set in the combined word.
- R7: `rsp_valid` is high exactly in the cycle after `acc_valid` was high. `rsp_allow` carries the verdict in that cycle and is 0 whenever `rsp_valid` is 0.
- R8: A denied access sets `fault_flag` and captures its address, ID, level and kind. While the flag stays set, later denials neither change the flag nor change the captured details.
- R9: Writing bit 0 = 1 at index `NUM_PROG`, select 1, clears `fault_flag`. If a denial happens in the same cycle as the clear, the new denial is captured and the flag stays set.
- R10: After reset there is no response and no fault. Every programmable range has start all-ones and end zero, so it matches nothing. The default mode is deny.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register index (upper bits) and select (low two bits) |
| reg_wdata | input | WDATA_W | Register write data |
| acc_valid | input | 1 | Access request present |
| acc_addr | input | ADDR_W | Access address |
| acc_id | input | ID_W | Requestor privilege ID |
| acc_priv | input | 1 | 0 user, 1 supervisor |
| acc_type | input | 2 | 0 read, 1 write, 2 execute, 3 reserved |
| rsp_valid | output | 1 | Verdict valid, one cycle after request |
| rsp_allow | output | 1 | 1 allowed, 0 denied |
| fault_flag | output | 1 | Sticky fault indicator |
| fault_addr | output | ADDR_W | Captured address of the first uncleared denial |
| fault_id | output | ID_W | Captured privilege ID |
| fault_priv | output | 1 | Captured privilege level |
| fault_type | output | 2 | Captured access kind |

## Verification
The bench probes accesses at exactly the start and end address of a range and one past the end. A comparator with the wrong strictness would flip the verdict at those edges. It programs an inverted range and overlapping ranges with conflicting ID grants: a design that ORed the words, or treated an inverted range as matching, would allow what must be denied. It uses IDs above 11 so that an out-of-range index into the ID bits shows up. It also issues a denial while the flag is already set, and another in the same cycle as the clear: a design that overwrote the captured details, or let the clear win, reports the wrong fault.

// File: rtl/mpu_pkg.sv
package mpu_pkg;
  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_kind_e;

  localparam int PERM_W    = 32;
  localparam int ANY_ID_B  = 9;
  localparam int ID_BASE_B = 10;
  localparam int ID_GRANTS = 12;
  localparam int SUP_OFS   = 3;
endpackage

// File: rtl/mpu_range_match.sv
module mpu_range_match #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] lo_addr,
  input  logic [ADDR_W-1:0] hi_addr,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  // Inclusive on both ends; an inverted pair can never satisfy both.
  assign hit = (addr >= lo_addr) && (addr <= hi_addr);
endmodule

// File: rtl/mpu_perm_check.sv
module mpu_perm_check
  import mpu_pkg::*;
#(
  parameter int ID_W = 4
) (
  input  logic [PERM_W-1:0] perm,
  input  logic              any_hit,
  input  logic              dflt_ok,
  input  logic [ID_W-1:0]   id,
  input  logic              priv,
  input  logic [1:0]        kind,
  output logic              allow
);
  logic kind_ok;
  logic id_ok;
  int   ofs;

  always_comb begin
    ofs = priv ? SUP_OFS : 0;
    case (acc_kind_e'(kind))
      ACC_EXEC:  kind_ok = perm[ofs + 0];
      ACC_WRITE: kind_ok = perm[ofs + 1];
      ACC_READ:  kind_ok = perm[ofs + 2];
      default:   kind_ok = 1'b0;
    endcase
  end

  always_comb begin
    id_ok = perm[ANY_ID_B];
    for (int n = 0; n < ID_GRANTS; n++) begin
      if (int'(id) == n) id_ok = perm[ID_BASE_B + n];
    end
  end

  assign allow = any_hit ? (kind_ok & id_ok) : dflt_ok;
endmodule

// File: rtl/mpu_range_checker.sv
module mpu_range_checker
  import mpu_pkg::*;
#(
  parameter int                 ADDR_W         = 32,
  parameter int                 NUM_PROG       = 4,
  parameter int                 ID_W           = 4,
  parameter logic [ADDR_W-1:0]  FIXED_START    = 'h800,
  parameter logic [ADDR_W-1:0]  FIXED_END      = 'hBFF,
  parameter logic [PERM_W-1:0]  FIXED_PERM_RST = '0,
  localparam int                REG_IDX_W      = $clog2(NUM_PROG + 1),
  localparam int                REG_AW         = REG_IDX_W + 2,
  localparam int                WDATA_W        = (ADDR_W > PERM_W) ? ADDR_W : PERM_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_we,
  input  logic [REG_AW-1:0]  reg_addr,
  input  logic [WDATA_W-1:0] reg_wdata,
  input  logic               acc_valid,
  input  logic [ADDR_W-1:0]  acc_addr,
  input  logic [ID_W-1:0]    acc_id,
  input  logic               acc_priv,
  input  logic [1:0]         acc_type,
  output logic               rsp_valid,
  output logic               rsp_allow,
  output logic               fault_flag,
  output logic [ADDR_W-1:0]  fault_addr,
  output logic [ID_W-1:0]    fault_id,
  output logic               fault_priv,
  output logic [1:0]         fault_type
);
  localparam int NR = NUM_PROG + 1;

  logic [REG_IDX_W-1:0] wr_idx;
  logic [1:0]           wr_sel;
  logic                 cfg_wr;
  logic                 clr;

  logic [ADDR_W-1:0] rng_lo   [NUM_PROG];
  logic [ADDR_W-1:0] rng_hi   [NUM_PROG];
  logic [PERM_W-1:0] all_perm [NR];
  logic [PERM_W-1:0] fixed_perm;
  logic              dflt_ok;

  logic [NR-1:0]     hit;
  logic              any_hit;
  logic [PERM_W-1:0] comb_perm;
  logic              allow_c;
  logic              deny_now;

  assign wr_idx = reg_addr[REG_AW-1:2];
  assign wr_sel = reg_addr[1:0];
  assign cfg_wr = reg_we && (wr_idx == REG_IDX_W'(NUM_PROG));
  assign clr    = cfg_wr && (wr_sel == 2'd1) && reg_wdata[0];

  // Programmable ranges: storage plus comparator per range
  for (genvar g = 0; g < NUM_PROG; g++) begin : g_prog
    logic [PERM_W-1:0] perm_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        rng_lo[g] <= '1;
        rng_hi[g] <= '0;
        perm_q    <= '0;
      end else if (reg_we && (wr_idx == REG_IDX_W'(g))) begin
        case (wr_sel)
          2'd0:    rng_lo[g] <= reg_wdata[ADDR_W-1:0];
          2'd1:    rng_hi[g] <= reg_wdata[ADDR_W-1:0];
          2'd2:    perm_q    <= reg_wdata[PERM_W-1:0];
          default: ;
        endcase
      end
    end
    assign all_perm[g] = perm_q;

    mpu_range_match #(.ADDR_W(ADDR_W)) u_match (
      .lo_addr (rng_lo[g]),
      .hi_addr (rng_hi[g]),
      .addr    (acc_addr),
      .hit     (hit[g])
    );
  end

  // Fixed range: constant bounds, programmable permission word
  mpu_range_match #(.ADDR_W(ADDR_W)) u_fixed_match (
    .lo_addr (FIXED_START),
    .hi_addr (FIXED_END),
    .addr    (acc_addr),
    .hit     (hit[NUM_PROG])
  );
  assign all_perm[NUM_PROG] = fixed_perm;

  always_ff @(posedge clk) begin
    if (rst) begin
      fixed_perm <= FIXED_PERM_RST;
      dflt_ok    <= 1'b0;
    end else if (cfg_wr) begin
      if (wr_sel == 2'd0) dflt_ok    <= reg_wdata[0];
      if (wr_sel == 2'd2) fixed_perm <= reg_wdata[PERM_W-1:0];
    end
  end

  // Overlap resolution: every matching range must grant
  always_comb begin
    comb_perm = '1;
    for (int i = 0; i < NR; i++) begin
      if (hit[i]) comb_perm &= all_perm[i];
    end
  end
  assign any_hit = |hit;

  mpu_perm_check #(.ID_W(ID_W)) u_check (
    .perm    (comb_perm),
    .any_hit (any_hit),
    .dflt_ok (dflt_ok),
    .id      (acc_id),
    .priv    (acc_priv),
    .kind    (acc_type),
    .allow   (allow_c)
  );

  assign deny_now = acc_valid && !allow_c;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_allow <= 1'b0;
    end else begin
      rsp_valid <= acc_valid;
      rsp_allow <= acc_valid && allow_c;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fault_flag <= 1'b0;
      fault_addr <= '0;
      fault_id   <= '0;
      fault_priv <= 1'b0;
      fault_type <= '0;
    end else if (deny_now && (!fault_flag || clr)) begin
      fault_flag <= 1'b1;
      fault_addr <= acc_addr;
      fault_id   <= acc_id;
      fault_priv <= acc_priv;
      fault_type <= acc_type;
    end else if (clr) begin
      fault_flag <= 1'b0;
    end
  end

  // Assertions
  p_rsp_follows_req_r7: assert property (@(posedge clk) disable iff (rst)
    acc_valid |=> rsp_valid);
  p_rsp_idle_r7: assert property (@(posedge clk) disable iff (rst)
    !acc_valid |=> (!rsp_valid && !rsp_allow));
  p_nohit_mode_r4: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !any_hit) |=> (rsp_allow == $past(dflt_ok)));
  p_deny_flags_r8: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_allow) |-> fault_flag);
  p_flag_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    (fault_flag && !clr) |=> (fault_flag && $stable(fault_addr) && $stable(fault_id)));
  p_clear_r9: assert property (@(posedge clk) disable iff (rst)
    (clr && !deny_now) |=> !fault_flag);
  p_clear_race_r9: assert property (@(posedge clk) disable iff (rst)
    (clr && deny_now) |=> (fault_flag && fault_addr == $past(acc_addr)));
endmodule

// File: tb/mpu_range_checker_tb.sv
`timescale 1ns/1ps
module mpu_range_checker_tb;
  localparam int AW = 32;
  localparam int NP = 4;
  localparam int IW = 4;
  localparam int RAW = 5;
  localparam logic [31:0] FS = 32'h800;
  localparam logic [31:0] FE = 32'hBFF;

  logic clk = 0;
  logic rst = 1;
  logic reg_we = 0;
  logic [RAW-1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic acc_valid = 0;
  logic [AW-1:0] acc_addr = '0;
  logic [IW-1:0] acc_id = '0;
  logic acc_priv = 0;
  logic [1:0] acc_type = '0;
  logic rsp_valid, rsp_allow, fault_flag, fault_priv;
  logic [AW-1:0] fault_addr;
  logic [IW-1:0] fault_id;
  logic [1:0] fault_type;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] m_lo [NP+1];
  logic [31:0] m_hi [NP+1];
  logic [31:0] m_perm [NP+1];
  bit m_dflt;
  bit m_flag;
  logic [31:0] m_faddr;
  logic [3:0] m_fid;
  bit m_fpriv;
  logic [1:0] m_ftype;

  always #2.5 clk = ~clk;

  mpu_range_checker #(.ADDR_W(AW), .NUM_PROG(NP), .ID_W(IW),
    .FIXED_START(FS), .FIXED_END(FE), .FIXED_PERM_RST(32'h0)) u_dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_id(acc_id), .acc_priv(acc_priv),
    .acc_type(acc_type), .rsp_valid(rsp_valid), .rsp_allow(rsp_allow),
    .fault_flag(fault_flag), .fault_addr(fault_addr), .fault_id(fault_id),
    .fault_priv(fault_priv), .fault_type(fault_type));

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit exp_allow(input logic [31:0] a, input logic [3:0] id, input bit pr, input logic [1:0] ty);
    logic [31:0] p = '1;
    bit any = 0;
    bit kok, iok;
    for (int i = 0; i <= NP; i++) begin
      if (a >= m_lo[i] && a <= m_hi[i]) begin
        any = 1;
        p &= m_perm[i];
      end
    end
    if (!any) return m_dflt;
    kok = (ty == 2'd3) ? 1'b0 : p[(pr ? 3 : 0) + (ty == 2'd0 ? 2 : (ty == 2'd1 ? 1 : 0))];
    iok = (id > 11) ? p[9] : p[10 + id];
    return kok && iok;
  endfunction

  task automatic wr(input int idx, input int sel, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = RAW'((idx << 2) | sel); reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
    if (idx < NP) begin
      if (sel == 0) m_lo[idx] = d;
      if (sel == 1) m_hi[idx] = d;
      if (sel == 2) m_perm[idx] = d;
    end else if (idx == NP) begin
      if (sel == 0) m_dflt = d[0];
      if (sel == 1 && d[0]) m_flag = 0;
      if (sel == 2) m_perm[NP] = d;
    end
  endtask

  // One access, optionally with a fault clear in the same cycle; checks verdict and fault state
  task automatic access(input logic [31:0] a, input logic [3:0] id, input bit pr,
                        input logic [1:0] ty, input bit with_clr, input string req);
    bit e;
    e = exp_allow(a, id, pr, ty);
    @(negedge clk);
    acc_valid = 1; acc_addr = a; acc_id = id; acc_priv = pr; acc_type = ty;
    if (with_clr) begin
      reg_we = 1; reg_addr = RAW'((NP << 2) | 1); reg_wdata = 32'h1;
    end
    @(negedge clk);
    acc_valid = 0; reg_we = 0;
    if (!e && (!m_flag || with_clr)) begin
      m_flag = 1; m_faddr = a; m_fid = id; m_fpriv = pr; m_ftype = ty;
    end else if (with_clr) m_flag = 0;
    chk(rsp_valid == 1'b1, {req, "/R7 valid"}, rsp_valid, 1);
    chk(rsp_allow == e, {req, " verdict"}, rsp_allow, e);
    chk(fault_flag == m_flag, {req, "/R8 flag"}, fault_flag, m_flag);
    if (m_flag)
      chk(fault_addr == m_faddr && fault_id == m_fid && fault_priv == m_fpriv && fault_type == m_ftype,
          {req, "/R8 details"}, {fault_addr, fault_id, fault_priv, fault_type},
          {m_faddr, m_fid, m_fpriv, m_ftype});
  endtask

  localparam logic [31:0] UR = 32'h4, UW = 32'h2, SR = 32'h20, AIX = 32'h200;
  function automatic logic [31:0] aid(input int n); return 32'h1 << (10 + n); endfunction

  initial begin
    for (int i = 0; i < NP; i++) begin m_lo[i] = '1; m_hi[i] = '0; m_perm[i] = '0; end
    m_lo[NP] = FS; m_hi[NP] = FE; m_perm[NP] = '0;
    m_dflt = 0; m_flag = 0; m_faddr = '0; m_fid = '0; m_fpriv = 0; m_ftype = '0;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R10 reset state
    chk(rsp_valid == 0 && rsp_allow == 0, "R10 rsp idle", {rsp_valid, rsp_allow}, 0);
    chk(fault_flag == 0, "R10 no fault", fault_flag, 0);
    access(32'h100, 4'd0, 1'b1, 2'd0, 0, "R10 default deny");
    chk(rsp_allow == 0, "R10 deny at reset", rsp_allow, 0);
    wr(NP, 1, 32'h1);
    chk(fault_flag == 0, "R9 clear", fault_flag, 0);
    // R4 default allow
    wr(NP, 0, 32'h1);
    access(32'h100, 4'd2, 1'b0, 2'd1, 0, "R4 assume allow");
    chk(rsp_allow == 1, "R4 allow", rsp_allow, 1);
    wr(NP, 0, 32'h0);
    // R2 boundaries
    wr(0, 0, 32'h100); wr(0, 1, 32'h1FF); wr(0, 2, UR | aid(3) | AIX);
    access(32'h100, 4'd3, 1'b0, 2'd0, 0, "R2 start");
    chk(rsp_allow == 1, "R2 start allow", rsp_allow, 1);
    access(32'h1FF, 4'd3, 1'b0, 2'd0, 0, "R2 end");
    chk(rsp_allow == 1, "R2 end allow", rsp_allow, 1);
    wr(NP, 1, 32'h1);
    access(32'h200, 4'd3, 1'b0, 2'd0, 0, "R2 past end");
    chk(rsp_allow == 0 && fault_addr == 32'h200, "R2 past end deny", rsp_allow, 0);
    wr(NP, 1, 32'h1);
    // R5 level/kind bits
    access(32'h150, 4'd3, 1'b0, 2'd1, 0, "R5 user write");
    chk(rsp_allow == 0, "R5 user write deny", rsp_allow, 0);
    access(32'h150, 4'd3, 1'b1, 2'd0, 0, "R5 sup read");
    access(32'h150, 4'd3, 1'b0, 2'd3, 0, "R5 reserved kind");
    wr(NP, 1, 32'h1);
    // R6 ID bits
    access(32'h150, 4'd4, 1'b0, 2'd0, 0, "R6 id4 deny");
    chk(rsp_allow == 0, "R6 id not granted", rsp_allow, 0);
    access(32'h150, 4'd13, 1'b0, 2'd0, 0, "R6 id13 via any-id bit");
    chk(rsp_allow == 1, "R6 high id allow", rsp_allow, 1);
    wr(NP, 1, 32'h1);
    // R3 overlap
    wr(1, 0, 32'h180); wr(1, 1, 32'h2FF); wr(1, 2, UR | UW | aid(5));
    access(32'h180, 4'd3, 1'b0, 2'd0, 0, "R3 overlap deny");
    chk(rsp_allow == 0, "R3 and", rsp_allow, 0);
    access(32'h150, 4'd3, 1'b0, 2'd0, 0, "R3 single range");
    wr(NP, 1, 32'h1);
    // R2 inverted range
    wr(2, 0, 32'h400); wr(2, 1, 32'h3FF); wr(2, 2, 32'hFFFF_FFFF);
    access(32'h400, 4'd0, 1'b0, 2'd0, 0, "R2 inverted no hit");
    chk(rsp_allow == 0, "R2 inverted deny", rsp_allow, 0);
    wr(NP, 1, 32'h1);
    // R1 fixed range
    access(FS, 4'd0, 1'b1, 2'd0, 0, "R1 fixed reset perm");
    wr(NP, 1, 32'h1);
    wr(NP, 2, SR | aid(0));
    access(FE, 4'd0, 1'b1, 2'd0, 0, "R1 fixed end");
    chk(rsp_allow == 1, "R1 fixed allow", rsp_allow, 1);
    // R8 hold, R9 clear race
    access(32'h900, 4'd1, 1'b0, 2'd2, 0, "R8 first deny");
    access(32'hA00, 4'd2, 1'b1, 2'd1, 0, "R8 second deny held");
    chk(fault_addr == 32'h900, "R8 first kept", fault_addr, 32'h900);
    access(32'hA04, 4'd6, 1'b1, 2'd1, 1, "R9 clear with deny");
    chk(fault_flag == 1 && fault_addr == 32'hA04, "R9 new capture", fault_addr, 32'hA04);
    // idle cycle: R7
    @(negedge clk);
    chk(rsp_valid == 0, "R7 idle", rsp_valid, 0);
    // Random phase
    for (int k = 0; k < 400; k++) begin
      if (k % 25 == 0) begin
        for (int r = 0; r < NP; r++) begin
          logic [31:0] lo = $urandom % 4096;
          wr(r, 0, lo);
          wr(r, 1, lo + ($urandom % 1024) - 128);
          wr(r, 2, $urandom);
        end
        wr(NP, 2, $urandom);
        wr(NP, 0, $urandom % 2);
      end
      access(($urandom % 8 == 0) ? $urandom : $urandom % 4096, 4'($urandom), 1'($urandom),
             2'($urandom), ($urandom % 10 == 0), "R3/R5/R6 random");
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule